// File: doc/BRIEF.md
# Exception Level Router

This block sits next to a processor pipeline and handles the privilege-level side of taking and leaving exceptions. When the pipeline raises an exception it gives the class (synchronous, IRQ, FIQ or system error), the current processor state word, which carries the current level, the return PC and a syndrome value. The block chooses the target privilege level from the routing-control bits of the two upper levels. It saves the state word and the return PC into that level's bank, and also saves the syndrome when the class needs it. One cycle later it hands the pipeline a new state word and a vector PC to load.

On an exception-return request the block reads the bank of the current level and hands back the saved state word and the saved PC through the same two load outputs. Which upper levels exist is fixed by parameters. So are the vector base address of each level, the spacing between vector slots and the offset used for exceptions that come from a lower level. The pipeline owns the live state word: it loads `state_next` when `state_load` pulses and drives the result back on `cur_state`. A read port shows the bank contents of any level.

Top module: `exc_level_router`

## Requirements
- R1: After reset `state_load` and `pc_load` are low, and every bank (levels 1 to 3) reads back zero for saved state, return address and syndrome.
- R2: An exception never targets level 0 and never targets a level below the current level. The current level is `cur_state[3:2]`.
- R3: A synchronous exception (class 0) is taken at the current level, or at level 1 when the current level is 0.
- R4: Classes 1 (IRQ), 2 (FIQ) and 3 (system error) each use their own routing bit, at index class-1 in `route_l3` and in `route_l2`. If the level-3 bit is set and level 3 exists, the target is 3. Otherwise, if the level-2 bit is set, level 2 exists and `nonsecure` is 1, the target is 2. Otherwise the target is the current level, raised to 1 if it is 0. The result is never below the current level.
- R5: On entry the target level's bank stores `cur_state` as its saved state and `ret_pc` as its return address. The new values show on the read port in the cycle after the request.
- R6: The target level's syndrome is written with `exc_syndrome` only for classes 0 and 3. Classes 1 and 2 leave it unchanged.
- R7: One cycle after an entry request, `pc_load` pulses for exactly one cycle with `pc_next` = base of the target level + class*0x80, plus 0x200 when the current level is below the target. The default bases are 0x1000, 0x2000 and 0x3000 for levels 1, 2 and 3. No load pulses without a request.
- R8: The entry state word is `cur_state` with bits [3:2] replaced by the target level and mask bits [9:6] all set to 1. All other bits pass through unchanged.
- R9: An exception return at current level n≥1 pulses `state_load` and `pc_load` one cycle later, with the saved state and the return address of level n. A return request at level 0 is ignored and produces no load.
- R10: When an entry and a return are requested in the same cycle, the entry is performed and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req | input | 1 | Exception entry request, one cycle |
| exc_class | input | 2 | 0 sync, 1 IRQ, 2 FIQ, 3 system error |
| exc_syndrome | input | SYN_W | Syndrome value for the target level |
| ret_pc | input | ADDR_W | Return PC to save |
| eret_req | input | 1 | Exception return request, one cycle |
| cur_state | input | PS_W | Live processor state word, level in [3:2] |
| nonsecure | input | 1 | Current security state is non-secure |
| route_l3 | input | 3 | Level-3 routing bits: [0] IRQ, [1] FIQ, [2] system error |
| route_l2 | input | 3 | Level-2 routing bits, same order |
| rd_level | input | 2 | Level whose bank is shown on the read port |
| state_load | output | 1 | Pulse: load `state_next` into the live state |
| state_next | output | PS_W | New processor state word |
| pc_load | output | 1 | Pulse: load `pc_next` into the PC |
| pc_next | output | ADDR_W | Vector address or restored PC |
| rd_saved_state | output | PS_W | Saved state of `rd_level` |
| rd_ret_addr | output | ADDR_W | Return address of `rd_level` |
| rd_syndrome | output | SYN_W | Syndrome of `rd_level` |

## Verification
Every result is due exactly one clock edge after the request is captured. The load pulses, the new state, the vector or restored PC, and the bank contents on the combinational read port all change at the edge that captures `exc_req` or `eret_req`. The bench drives each request on a falling edge and holds it through one rising edge. It then samples all outputs and the read port at the next falling edge, where the pulses are high. The following cycle confirms that the pulses have dropped. For the ignored cases (an IRQ or FIQ over an older syndrome, a return at level 0, a return that loses to an entry), the bench reads the bank or the load outputs at that same falling edge, before any further request.

// File: rtl/exc_router_pkg.sv
package exc_router_pkg;

   typedef enum logic [1:0] {
      EXC_SYNC = 2'd0,
      EXC_IRQ  = 2'd1,
      EXC_FIQ  = 2'd2,
      EXC_SERR = 2'd3
   } exc_class_e;

   localparam int LVL_LSB  = 2;
   localparam int LVL_W    = 2;
   localparam int MASK_LSB = 6;
   localparam int MASK_W   = 4;
   localparam int MIN_PS_W = MASK_LSB + MASK_W;

   function automatic logic [1:0] lvl_max(input logic [1:0] a, input logic [1:0] b);
      return (a > b) ? a : b;
   endfunction

   function automatic logic class_is_async(input logic [1:0] cls);
      return cls != EXC_SYNC;
   endfunction

   function automatic logic class_has_syn(input logic [1:0] cls);
      return (cls == EXC_SYNC) || (cls == EXC_SERR);
   endfunction

endpackage

// File: rtl/exc_route_sel.sv
module exc_route_sel
   import exc_router_pkg::*;
#(
   parameter int HAS_L2 = 1,
   parameter int HAS_L3 = 1
) (
   input  logic [1:0] cls,
   input  logic [1:0] cur_lvl,
   input  logic       nonsec,
   input  logic [2:0] route3,
   input  logic [2:0] route2,
   output logic [1:0] tgt_lvl
);

   logic       bit3;
   logic       bit2;
   logic [1:0] routed;

   always_comb begin
      case (cls)
         EXC_IRQ:  begin bit3 = route3[0]; bit2 = route2[0]; end
         EXC_FIQ:  begin bit3 = route3[1]; bit2 = route2[1]; end
         EXC_SERR: begin bit3 = route3[2]; bit2 = route2[2]; end
         default:  begin bit3 = 1'b0;      bit2 = 1'b0;      end
      endcase
   end

   always_comb begin
      routed = cur_lvl;
      if (class_is_async(cls)) begin
         if (bit3 && (HAS_L3 != 0))
            routed = 2'd3;
         else if (bit2 && (HAS_L2 != 0) && nonsec)
            routed = 2'd2;
      end
      tgt_lvl = lvl_max(lvl_max(routed, cur_lvl), 2'd1);
   end

endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen #(
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] BASE_L1   = 'h1000,
   parameter logic [ADDR_W-1:0] BASE_L2   = 'h2000,
   parameter logic [ADDR_W-1:0] BASE_L3   = 'h3000,
   parameter int unsigned       STRIDE    = 'h80,
   parameter int unsigned       LOWER_OFS = 'h200
) (
   input  logic [1:0]        cls,
   input  logic [1:0]        cur_lvl,
   input  logic [1:0]        tgt_lvl,
   output logic [ADDR_W-1:0] vec
);

   localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(STRIDE);
   localparam logic [ADDR_W-1:0] LOWER_V  = ADDR_W'(LOWER_OFS);

   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] slot;

   always_comb begin
      case (tgt_lvl)
         2'd2:    base = BASE_L2;
         2'd3:    base = BASE_L3;
         default: base = BASE_L1;
      endcase
      slot = ADDR_W'(cls) * STRIDE_V;
      vec  = base + slot + ((cur_lvl < tgt_lvl) ? LOWER_V : '0);
   end

endmodule

// File: rtl/exc_level_bank.sv
module exc_level_bank #(
   parameter int ADDR_W = 32,
   parameter int PS_W   = 16,
   parameter int SYN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              syn_en,
   input  logic [PS_W-1:0]   state_in,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [SYN_W-1:0]  syn_in,
   output logic [PS_W-1:0]   state_q,
   output logic [ADDR_W-1:0] pc_q,
   output logic [SYN_W-1:0]  syn_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
         pc_q    <= '0;
      end else if (wr_en) begin
         state_q <= state_in;
         pc_q    <= pc_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         syn_q <= '0;
      else if (wr_en && syn_en)
         syn_q <= syn_in;
   end

endmodule

// File: rtl/exc_level_router.sv
module exc_level_router
   import exc_router_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter int                PS_W      = 16,
   parameter int                SYN_W     = 16,
   parameter int                HAS_L2    = 1,
   parameter int                HAS_L3    = 1,
   parameter logic [ADDR_W-1:0] BASE_L1   = 'h1000,
   parameter logic [ADDR_W-1:0] BASE_L2   = 'h2000,
   parameter logic [ADDR_W-1:0] BASE_L3   = 'h3000,
   parameter int unsigned       STRIDE    = 'h80,
   parameter int unsigned       LOWER_OFS = 'h200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_req,
   input  logic [1:0]        exc_class,
   input  logic [SYN_W-1:0]  exc_syndrome,
   input  logic [ADDR_W-1:0] ret_pc,
   input  logic              eret_req,
   input  logic [PS_W-1:0]   cur_state,
   input  logic              nonsecure,
   input  logic [2:0]        route_l3,
   input  logic [2:0]        route_l2,
   input  logic [1:0]        rd_level,
   output logic              state_load,
   output logic [PS_W-1:0]   state_next,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_next,
   output logic [PS_W-1:0]   rd_saved_state,
   output logic [ADDR_W-1:0] rd_ret_addr,
   output logic [SYN_W-1:0]  rd_syndrome
);

   localparam int NUM_LVL = 4;
   localparam logic [PS_W-1:0] LVL_FIELD  = PS_W'({LVL_W{1'b1}}) << LVL_LSB;
   localparam logic [PS_W-1:0] MASK_FIELD = PS_W'({MASK_W{1'b1}}) << MASK_LSB;

   if (PS_W < MIN_PS_W) begin : g_bad_psw
      $error("PS_W too small for level and mask fields");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W too small for vector offsets");
   end
   if (SYN_W < 1) begin : g_bad_syn
      $error("SYN_W must be at least 1");
   end
   if ((HAS_L2 < 0) || (HAS_L2 > 1) || (HAS_L3 < 0) || (HAS_L3 > 1)) begin : g_bad_has
      $error("HAS_L2 and HAS_L3 must be 0 or 1");
   end

   logic [1:0]        cur_lvl;
   logic [1:0]        tgt_lvl;
   logic [ADDR_W-1:0] vec_addr;
   logic              do_entry;
   logic              do_return;
   logic [PS_W-1:0]   entry_state;

   logic [PS_W-1:0]   bank_state [NUM_LVL];
   logic [ADDR_W-1:0] bank_pc    [NUM_LVL];
   logic [SYN_W-1:0]  bank_syn   [NUM_LVL];

   assign cur_lvl   = cur_state[LVL_LSB +: LVL_W];
   assign do_entry  = exc_req;
   assign do_return = eret_req && !exc_req && (cur_lvl != 2'd0);

   exc_route_sel #(
      .HAS_L2 (HAS_L2),
      .HAS_L3 (HAS_L3)
   ) u_route (
      .cls     (exc_class),
      .cur_lvl (cur_lvl),
      .nonsec  (nonsecure),
      .route3  (route_l3),
      .route2  (route_l2),
      .tgt_lvl (tgt_lvl)
   );

   exc_vec_gen #(
      .ADDR_W    (ADDR_W),
      .BASE_L1   (BASE_L1),
      .BASE_L2   (BASE_L2),
      .BASE_L3   (BASE_L3),
      .STRIDE    (STRIDE),
      .LOWER_OFS (LOWER_OFS)
   ) u_vec (
      .cls     (exc_class),
      .cur_lvl (cur_lvl),
      .tgt_lvl (tgt_lvl),
      .vec     (vec_addr)
   );

   assign bank_state[0] = '0;
   assign bank_pc[0]    = '0;
   assign bank_syn[0]   = '0;

   for (genvar g = 1; g < NUM_LVL; g++) begin : g_lvl
      localparam bit PRESENT = (g == 1) || ((g == 2) && (HAS_L2 != 0)) ||
                               ((g == 3) && (HAS_L3 != 0));
      if (PRESENT) begin : g_bank
         logic wr_here;
         assign wr_here = do_entry && (tgt_lvl == 2'(g));
         exc_level_bank #(
            .ADDR_W (ADDR_W),
            .PS_W   (PS_W),
            .SYN_W  (SYN_W)
         ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_here),
            .syn_en   (class_has_syn(exc_class)),
            .state_in (cur_state),
            .pc_in    (ret_pc),
            .syn_in   (exc_syndrome),
            .state_q  (bank_state[g]),
            .pc_q     (bank_pc[g]),
            .syn_q    (bank_syn[g])
         );
      end else begin : g_absent
         assign bank_state[g] = '0;
         assign bank_pc[g]    = '0;
         assign bank_syn[g]   = '0;
      end
   end

   always_comb begin
      entry_state = cur_state & ~(LVL_FIELD | MASK_FIELD);
      entry_state = entry_state | MASK_FIELD | (PS_W'(tgt_lvl) << LVL_LSB);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_load <= 1'b0;
         pc_load    <= 1'b0;
         state_next <= '0;
         pc_next    <= '0;
      end else begin
         state_load <= do_entry || do_return;
         pc_load    <= do_entry || do_return;
         if (do_entry) begin
            state_next <= entry_state;
            pc_next    <= vec_addr;
         end else if (do_return) begin
            state_next <= bank_state[cur_lvl];
            pc_next    <= bank_pc[cur_lvl];
         end
      end
   end

   assign rd_saved_state = bank_state[rd_level];
   assign rd_ret_addr    = bank_pc[rd_level];
   assign rd_syndrome    = bank_syn[rd_level];

endmodule

// File: rtl/exc_level_router_chk.sv
module exc_level_router_chk #(
   parameter int ADDR_W = 32,
   parameter int PS_W   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exc_req,
   input logic [1:0]        exc_class,
   input logic              eret_req,
   input logic [PS_W-1:0]   cur_state,
   input logic              state_load,
   input logic [PS_W-1:0]   state_next,
   input logic              pc_load,
   input logic [ADDR_W-1:0] pc_next
);

   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_ENTRY_NOT_L0: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(exc_req) |-> state_load && (state_next[3:2] != 2'd0)); // R2

   AST_ENTRY_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(exc_req) |-> state_next[3:2] >= $past(cur_state[3:2])); // R2

   AST_SYNC_SAME_LVL: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(exc_req && (exc_class == 2'd0) && (cur_state[3:2] != 2'd0))
      |-> state_next[3:2] == $past(cur_state[3:2])); // R3

   AST_ENTRY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(exc_req) |-> (&state_next[9:6])); // R8

   AST_RET_L0_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(!exc_req && eret_req && (cur_state[3:2] == 2'd0))
      |-> !state_load && !pc_load); // R9

   AST_NO_SPURIOUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(!exc_req && !eret_req) |-> !pc_load && !state_load); // R7

endmodule

bind exc_level_router exc_level_router_chk #(
   .ADDR_W (ADDR_W),
   .PS_W   (PS_W)
) u_chk (.*);

// File: tb/exc_level_router_tb.sv
module exc_level_router_tb;

   localparam int ADDR_W = 32;
   localparam int PS_W   = 16;
   localparam int SYN_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              exc_req = 1'b0;
   logic [1:0]        exc_class = 2'd0;
   logic [SYN_W-1:0]  exc_syndrome = '0;
   logic [ADDR_W-1:0] ret_pc = '0;
   logic              eret_req = 1'b0;
   logic [PS_W-1:0]   cur_state = '0;
   logic              nonsecure = 1'b1;
   logic [2:0]        route_l3 = '0;
   logic [2:0]        route_l2 = '0;
   logic [1:0]        rd_level = 2'd1;
   logic              state_load;
   logic [PS_W-1:0]   state_next;
   logic              pc_load;
   logic [ADDR_W-1:0] pc_next;
   logic [PS_W-1:0]   rd_saved_state;
   logic [ADDR_W-1:0] rd_ret_addr;
   logic [SYN_W-1:0]  rd_syndrome;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   exc_level_router u_dut (
      .clk, .rst_n, .exc_req, .exc_class, .exc_syndrome, .ret_pc, .eret_req,
      .cur_state, .nonsecure, .route_l3, .route_l2, .rd_level,
      .state_load, .state_next, .pc_load, .pc_next,
      .rd_saved_state, .rd_ret_addr, .rd_syndrome
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [PS_W-1:0] mk_state(input logic [1:0] lvl);
      return (16'hA403 & ~16'h000C) | (16'(lvl) << 2);
   endfunction

   function automatic logic [1:0] exp_tgt(input logic [1:0] cls, input logic [1:0] lvl,
                                          input logic ns, input logic [2:0] r3,
                                          input logic [2:0] r2);
      logic [1:0] t;
      t = lvl;
      if (cls != 2'd0) begin
         if (r3[cls-2'd1]) t = 2'd3;
         else if (r2[cls-2'd1] && ns) t = 2'd2;
      end
      if (t < lvl) t = lvl;
      if (t == 2'd0) t = 2'd1;
      return t;
   endfunction

   function automatic logic [ADDR_W-1:0] exp_vec(input logic [1:0] cls, input logic [1:0] lvl,
                                                 input logic [1:0] t);
      logic [ADDR_W-1:0] b;
      b = 32'h1000 * 32'(t);
      return b + 32'h80 * 32'(cls) + ((lvl < t) ? 32'h200 : 32'h0);
   endfunction

   // Drive one entry and check every result one edge later.
   task automatic do_entry(input string req, input logic [1:0] cls, input logic [1:0] lvl,
                           input logic ns, input logic [2:0] r3, input logic [2:0] r2,
                           input logic [ADDR_W-1:0] pc, input logic [SYN_W-1:0] syn);
      logic [1:0] t;
      logic [PS_W-1:0] st;
      t  = exp_tgt(cls, lvl, ns, r3, r2);
      st = mk_state(lvl);
      @(negedge clk);
      exc_req = 1'b1; exc_class = cls; cur_state = st; nonsecure = ns;
      route_l3 = r3; route_l2 = r2; ret_pc = pc; exc_syndrome = syn; rd_level = t;
      @(negedge clk);
      exc_req = 1'b0;
      chk({req, " state_load"}, 64'(state_load), 64'd1);
      chk({req, " pc_load"}, 64'(pc_load), 64'd1);
      chk({req, " target level"}, 64'(state_next[3:2]), 64'(t));
      chk({req, " R8 entry state"}, 64'(state_next),
          64'((st & ~16'h03CC) | 16'h03C0 | (16'(t) << 2)));
      chk({req, " R7 vector"}, 64'(pc_next), 64'(exp_vec(cls, lvl, t)));
      chk({req, " R5 saved state"}, 64'(rd_saved_state), 64'(st));
      chk({req, " R5 return addr"}, 64'(rd_ret_addr), 64'(pc));
      @(negedge clk);
      chk({req, " R7 pulse ends"}, 64'(pc_load), 64'd0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 state_load", 64'(state_load), 64'd0);
      chk("R1 pc_load", 64'(pc_load), 64'd0);
      for (int l = 1; l < 4; l++) begin
         rd_level = 2'(l);
         #1;
         chk("R1 bank state", 64'(rd_saved_state), 64'd0);
         chk("R1 bank pc", 64'(rd_ret_addr), 64'd0);
         chk("R1 bank syndrome", 64'(rd_syndrome), 64'd0);
      end
   endtask

   task automatic t_sync();
      do_entry("R3 sync from L0", 2'd0, 2'd0, 1'b1, 3'b000, 3'b000, 32'h0000_4440, 16'h0011);
      do_entry("R3 sync at L2",   2'd0, 2'd2, 1'b1, 3'b111, 3'b111, 32'h0000_5550, 16'h0022);
      do_entry("R3 sync at L3",   2'd0, 2'd3, 1'b0, 3'b000, 3'b000, 32'h0000_6660, 16'h0033);
   endtask

   task automatic t_route();
      do_entry("R4 irq to L3",        2'd1, 2'd1, 1'b1, 3'b001, 3'b001, 32'h100, 16'h1);
      do_entry("R4 fiq to L2",        2'd2, 2'd1, 1'b1, 3'b000, 3'b010, 32'h104, 16'h2);
      do_entry("R4 fiq secure stays", 2'd2, 2'd1, 1'b0, 3'b000, 3'b010, 32'h108, 16'h3);
      do_entry("R4 serr no drop",     2'd3, 2'd3, 1'b1, 3'b000, 3'b100, 32'h10C, 16'h4);
      do_entry("R4 irq L0 to L1",     2'd1, 2'd0, 1'b1, 3'b000, 3'b000, 32'h110, 16'h5);
      do_entry("R4 fiq own bit only", 2'd2, 2'd0, 1'b1, 3'b101, 3'b101, 32'h114, 16'h6);
      do_entry("R2 serr L2 no drop",  2'd3, 2'd2, 1'b1, 3'b000, 3'b000, 32'h118, 16'h7);
   endtask

   task automatic t_syndrome();
      do_entry("R6 sync sets syn", 2'd0, 2'd1, 1'b1, 3'b000, 3'b000, 32'h200, 16'hAAAA);
      chk("R6 sync syndrome", 64'(rd_syndrome), 64'hAAAA);
      do_entry("R6 irq keeps syn", 2'd1, 2'd1, 1'b1, 3'b000, 3'b000, 32'h204, 16'h5555);
      chk("R6 irq syndrome unchanged", 64'(rd_syndrome), 64'hAAAA);
      do_entry("R6 fiq keeps syn", 2'd2, 2'd1, 1'b1, 3'b000, 3'b000, 32'h208, 16'h6666);
      chk("R6 fiq syndrome unchanged", 64'(rd_syndrome), 64'hAAAA);
      do_entry("R6 serr sets syn", 2'd3, 2'd1, 1'b1, 3'b000, 3'b000, 32'h20C, 16'h1234);
      chk("R6 serr syndrome", 64'(rd_syndrome), 64'h1234);
   endtask

   task automatic t_return();
      logic [PS_W-1:0] saved;
      saved = mk_state(2'd1);
      do_entry("R9 setup", 2'd1, 2'd1, 1'b1, 3'b000, 3'b001, 32'h0000_7770, 16'h0);
      @(negedge clk);
      cur_state = mk_state(2'd2) | 16'h03C0;
      eret_req = 1'b1;
      @(negedge clk);
      eret_req = 1'b0;
      chk("R9 return state_load", 64'(state_load), 64'd1);
      chk("R9 return pc_load", 64'(pc_load), 64'd1);
      chk("R9 restored state", 64'(state_next), 64'(saved));
      chk("R9 restored pc", 64'(pc_next), 64'h7770);
      @(negedge clk);
      cur_state = mk_state(2'd0);
      eret_req = 1'b1;
      @(negedge clk);
      eret_req = 1'b0;
      chk("R9 L0 return state_load", 64'(state_load), 64'd0);
      chk("R9 L0 return pc_load", 64'(pc_load), 64'd0);
   endtask

   task automatic t_priority();
      @(negedge clk);
      exc_req = 1'b1; eret_req = 1'b1; exc_class = 2'd0; cur_state = mk_state(2'd1);
      ret_pc = 32'h0000_8880; route_l3 = '0; route_l2 = '0; rd_level = 2'd1;
      @(negedge clk);
      exc_req = 1'b0; eret_req = 1'b0;
      chk("R10 entry wins pc", 64'(pc_next), 64'h1000);
      chk("R10 entry wins state", 64'(state_next), 64'((mk_state(2'd1) & ~16'h03CC) | 16'h03C4));
      chk("R10 bank written", 64'(rd_ret_addr), 64'h8880);
   endtask

   initial begin
      t_reset();
      t_sync();
      t_route();
      t_syndrome();
      t_return();
      t_priority();
      repeat (2) @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule